// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the control front end of a simulated byte-wide parallel NOR flash. It watches single-cycle bus writes (address, data, write enable) and recognises the unlock-prefixed command sequences that change the array: byte program, sector erase, block erase and chip erase. When a sequence completes, the block raises a one-cycle start pulse. It also presents the kind of operation, the target address and the program byte, and it holds them until the next start.

The block also switches between three modes: normal read, identification and query. In identification mode, a small read port returns the manufacturer and device codes. While the array timer drives `busy` high, every bus write is ignored. A write that breaks a sequence throws away the partial sequence, so the decoder falls back to waiting for a fresh unlock.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `op_start` is 0 and `op_kind` is 0 (none). No partial sequence is held, so a lone A0H write to 5555H followed by a data write starts nothing.
- R2: The writes AAH@5555H, 55H@2AAAH, A0H@5555H followed by any fourth write start a program. One cycle after the fourth write, `op_start` is 1, `op_kind` is 1, `op_addr` is the fourth write's address and `op_data` is its data. This holds even when that data is F0H.
- R3: The writes AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH followed by 30H at any address start a sector erase. `op_kind` is 2 and `op_addr` is the address with its low 12 bits cleared.
- R4: The same five-write prefix followed by 50H starts a block erase. `op_kind` is 3 and `op_addr` is the address with its low 16 bits cleared.
- R5: The same prefix followed by 10H at 5555H starts a chip erase, with `op_kind` 4 and `op_addr` 0. A 10H write to any other address starts nothing.
- R6: A write that does not fit the expected next step discards the partial sequence. The decoder then needs the full sequence again before it starts anything.
- R7: A write made while `busy` is 1 has no effect. The partial sequence and the mode are kept, and no start pulse follows.
- R8: The writes AAH@5555H, 55H@2AAAH, 90H@5555H enter identification mode (`mode` = 1). In that mode, `id_byte` is BFH for `rd_addr` 0 and D8H for `rd_addr` 1. It is 00H for any other address, and 00H in every other mode.
- R9: The writes AAH@5555H, 55H@2AAAH, 98H@5555H enter query mode (`mode` = 2). Query mode and identification mode are left only by the exit command. Any other completed command in these modes is treated as a mismatch.
- R10: Outside the program data step, a write of F0H at any address exits to read mode (`mode` = 0) and clears the partial sequence. This also covers an F0H that comes as the third write.
- R11: Unlock and chip-erase addresses are matched on the low 16 address bits only.
- R12: `op_start` lasts exactly one cycle. `op_kind`, `op_addr` and `op_data` keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| busy | input | 1 | Array operation in progress; writes ignored |
| rd_addr | input | ADDR_W | Read address for identification codes |
| op_start | output | 1 | One-cycle start pulse |
| op_kind | output | 3 | 0 none, 1 program, 2 sector, 3 block, 4 chip |
| op_addr | output | ADDR_W | Target address, aligned for erases |
| op_data | output | 8 | Program byte |
| mode | output | 2 | 0 read, 1 identification, 2 query |
| id_byte | output | 8 | Identification code for rd_addr |

## Verification
The bench sends complete program and erase sequences at several addresses, including aliased addresses that differ above bit 15. These show whether address matching and region alignment are right. Broken sequences test whether a mismatch really discards the partial state: one swaps an unlock data byte, one puts a chip-erase code at the wrong address, and one attempts a program from inside identification mode. Writes made under `busy` in the middle of a sequence, and an exit written under `busy`, show that busy writes are ignored rather than treated as aborts. Program data of F0H shows that the exit code is not recognised in the data step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [1:0] {MODE_READ = 2'd0, MODE_ID = 2'd1, MODE_QRY = 2'd2} mode_e;
    typedef enum logic [2:0] {OP_NONE = 3'd0, OP_PROG = 3'd1, OP_SECT = 3'd2,
                              OP_BLK = 3'd3, OP_CHIP = 3'd4} op_e;
    typedef enum logic [2:0] {ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5} step_e;
    localparam logic [7:0] CMD_KEY1  = 8'hAA;
    localparam logic [7:0] CMD_KEY2  = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_ID    = 8'h90;
    localparam logic [7:0] CMD_QRY   = 8'h98;
    localparam logic [7:0] CMD_EXIT  = 8'hF0;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_BLK   = 8'h50;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int MATCH_W = 16,
    parameter logic [MATCH_W-1:0] KEY_A = 16'h5555,
    parameter logic [MATCH_W-1:0] KEY_B = 16'h2AAA
) (
    input  logic [MATCH_W-1:0] addr_lo,
    output logic               hit_a,
    output logic               hit_b
);
    assign hit_a = (addr_lo == KEY_A);
    assign hit_b = (addr_lo == KEY_B);
endmodule

// File: rtl/fcd_align.sv
module fcd_align #(
    parameter int ADDR_W  = 20,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] sect_addr,
    output logic [ADDR_W-1:0] blk_addr
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LG;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LG;
    assign sect_addr = addr & SECT_MASK;
    assign blk_addr  = addr & BLK_MASK;
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
    parameter int ADDR_W = 20,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'hD8
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_byte
);
    always_comb begin
        id_byte = 8'h00;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      id_byte = MFR_ID;
            else if (rd_addr == ADDR_W'(1)) id_byte = DEV_ID;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MATCH_W = 16,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        mode,
    output logic [7:0]        id_byte
);
    typedef struct packed {
        step_e             step;
        mode_e             mode;
        logic              start;
        op_e               kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } state_t;

    state_t q, d;
    logic hit_a, hit_b;
    logic [ADDR_W-1:0] sect_addr, blk_addr;
    logic take;

    fcd_addr_match #(.MATCH_W(MATCH_W)) u_match (
        .addr_lo (wr_addr[MATCH_W-1:0]),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    fcd_align #(.ADDR_W(ADDR_W), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)) u_align (
        .addr      (wr_addr),
        .sect_addr (sect_addr),
        .blk_addr  (blk_addr)
    );

    fcd_id_rom #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .id_mode (q.mode == MODE_ID),
        .rd_addr (rd_addr),
        .id_byte (id_byte)
    );

    assign take = wr_en && !busy;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (take) begin
            if (q.step == ST_PGM) begin
                d.step  = ST_IDLE;
                d.start = 1'b1;
                d.kind  = OP_PROG;
                d.addr  = wr_addr;
                d.data  = wr_data;
            end else if (wr_data == CMD_EXIT) begin
                d.step = ST_IDLE;
                d.mode = MODE_READ;
            end else begin
                d.step = ST_IDLE;
                case (q.step)
                    ST_IDLE: if (hit_a && wr_data == CMD_KEY1) d.step = ST_U1;
                    ST_U1:   if (hit_b && wr_data == CMD_KEY2) d.step = ST_U2;
                    ST_U2: begin
                        if (hit_a && q.mode == MODE_READ) begin
                            case (wr_data)
                                CMD_PROG:  d.step = ST_PGM;
                                CMD_ERASE: d.step = ST_E3;
                                CMD_ID:    d.mode = MODE_ID;
                                CMD_QRY:   d.mode = MODE_QRY;
                                default:   d.step = ST_IDLE;
                            endcase
                        end
                    end
                    ST_E3:   if (hit_a && wr_data == CMD_KEY1) d.step = ST_E4;
                    ST_E4:   if (hit_b && wr_data == CMD_KEY2) d.step = ST_E5;
                    ST_E5: begin
                        if (wr_data == CMD_SECT) begin
                            d.start = 1'b1;
                            d.kind  = OP_SECT;
                            d.addr  = sect_addr;
                        end else if (wr_data == CMD_BLK) begin
                            d.start = 1'b1;
                            d.kind  = OP_BLK;
                            d.addr  = blk_addr;
                        end else if (wr_data == CMD_CHIP && hit_a) begin
                            d.start = 1'b1;
                            d.kind  = OP_CHIP;
                            d.addr  = '0;
                        end
                    end
                    default: d.step = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.step  <= ST_IDLE;
            q.mode  <= MODE_READ;
            q.start <= 1'b0;
            q.kind  <= OP_NONE;
            q.addr  <= '0;
            q.data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign op_start = q.start;
    assign op_kind  = q.kind;
    assign op_addr  = q.addr;
    assign op_data  = q.data;
    assign mode     = q.mode;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int ADDR_W  = 20,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              busy,
    input logic              op_start,
    input logic [2:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [1:0]        mode,
    input logic [7:0]        id_byte
);
    assert_start_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_en));
    assert_sect_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd2) |-> (op_addr[SECT_LG-1:0] == '0));
    assert_blk_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd3) |-> (op_addr[BLK_LG-1:0] == '0));
    assert_chip_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd4) |-> (op_addr == '0));
    assert_busy_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !op_start);
    assert_busy_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));
    assert_id_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1) |-> (id_byte == 8'h00));
    assert_qry_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !(wr_en && !busy && wr_data == 8'hF0)) |=> (mode == 2'd2));
    assert_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && wr_en && !busy && wr_data == 8'hF0) |=> (mode == 2'd0));
    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |-> ($stable(op_kind) && $stable(op_addr)));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .busy     (busy),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .mode     (mode),
    .id_byte  (id_byte)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 20;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic op_start;
    logic [2:0] op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0] op_data;
    logic [1:0] mode;
    logic [7:0] id_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";
    bit done = 1'b0;

    // reference model state
    int m_step = 0;
    int m_mode = 0;
    int m_start = 0;
    int m_kind = 0;
    int m_addr = 0;
    int m_data = 0;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .mode(mode), .id_byte(id_byte)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_mode = 0; m_start = 0; m_kind = 0; m_addr = 0; m_data = 0;
        end else begin
            int lo;
            bit is_a, is_b;
            m_start = 0;
            lo = int'(wr_addr) % 65536;
            is_a = (lo == 'h5555);
            is_b = (lo == 'h2AAA);
            if (wr_en && !busy) begin
                if (m_step == 3) begin
                    m_start = 1; m_kind = 1; m_addr = int'(wr_addr); m_data = int'(wr_data);
                    m_step = 0;
                end else if (wr_data == 8'hF0) begin
                    m_step = 0; m_mode = 0;
                end else begin
                    int nxt;
                    nxt = 0;
                    if (m_step == 0 && is_a && wr_data == 8'hAA) nxt = 1;
                    if (m_step == 1 && is_b && wr_data == 8'h55) nxt = 2;
                    if (m_step == 2 && is_a && m_mode == 0 && wr_data == 8'hA0) nxt = 3;
                    if (m_step == 2 && is_a && m_mode == 0 && wr_data == 8'h80) nxt = 4;
                    if (m_step == 2 && is_a && m_mode == 0 && wr_data == 8'h90) m_mode = 1;
                    if (m_step == 2 && is_a && m_mode == 0 && wr_data == 8'h98) m_mode = 2;
                    if (m_step == 4 && is_a && wr_data == 8'hAA) nxt = 5;
                    if (m_step == 5 && is_b && wr_data == 8'h55) nxt = 6;
                    if (m_step == 6) begin
                        if (wr_data == 8'h30) begin
                            m_start = 1; m_kind = 2; m_addr = int'(wr_addr) / 4096 * 4096;
                        end else if (wr_data == 8'h50) begin
                            m_start = 1; m_kind = 3; m_addr = int'(wr_addr) / 65536 * 65536;
                        end else if (wr_data == 8'h10 && is_a) begin
                            m_start = 1; m_kind = 4; m_addr = 0;
                        end
                    end
                    m_step = nxt;
                end
            end
        end
    end

    // compare every cycle, 3 ns after the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            int exp_id;
            exp_id = 0;
            if (m_mode == 1 && rd_addr == 0) exp_id = 'hBF;
            if (m_mode == 1 && rd_addr == 1) exp_id = 'hD8;
            check(tag, "op_start", int'(op_start), m_start);
            check(tag, "op_kind", int'(op_kind), m_kind);
            check(tag, "op_addr", int'(op_addr), m_addr);
            check(tag, "op_data", int'(op_data), m_data);
            check(tag, "mode", int'(mode), m_mode);
            check(tag, "id_byte", int'(id_byte), exp_id);
        end
    end

    task automatic wr(int a, int dt, bit b = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(dt); busy = b;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0;
    endtask

    task automatic unlock();
        wr('h5555, 'hAA);
        wr('h2AAA, 'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr('h5555, 'h80);
        unlock();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // a check of the ports at a quiet point, named by requirement
    task automatic spot(string req, int exp_kind, int exp_addr, int exp_mode);
        @(negedge clk);
        check(req, "spot op_kind", int'(op_kind), exp_kind);
        check(req, "spot op_addr", int'(op_addr), exp_addr);
        check(req, "spot mode", int'(mode), exp_mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset op_start", int'(op_start), 0);
        check("R1", "reset op_kind", int'(op_kind), 0);
        check("R1", "reset mode", int'(mode), 0);
        wr('h5555, 'hA0);
        wr('h01234, 'h77);
        spot("R1", 0, 0, 0);

        tag = "R2";
        unlock(); wr('h5555, 'hA0); wr('h45678, 'h3C); idle(2);
        spot("R2", 1, 'h45678, 0);
        unlock(); wr('h5555, 'hA0); wr('h00010, 'hF0); idle(2);
        check("R2", "program of F0 data", int'(op_data), 'hF0);

        tag = "R11";
        wr('h15555, 'hAA); wr('hF2AAA, 'h55); wr('h35555, 'hA0); wr('h00ABC, 'h5A); idle(2);
        spot("R11", 1, 'h00ABC, 0);

        tag = "R3";
        erase_prefix(); wr('h7ABCD, 'h30); idle(2);
        spot("R3", 2, 'h7A000, 0);
        tag = "R4";
        erase_prefix(); wr('h7ABCD, 'h50); idle(2);
        spot("R4", 3, 'h70000, 0);
        tag = "R5";
        erase_prefix(); wr('h01234, 'h10); idle(2);
        spot("R5", 3, 'h70000, 0);
        erase_prefix(); wr('h95555, 'h10); idle(2);
        spot("R5", 4, 0, 0);

        tag = "R6";
        unlock(); wr('h2AAA, 'h55); wr('h5555, 'hA0); wr('h00100, 'h11); idle(2);
        spot("R6", 4, 0, 0);
        wr('h5555, 'hAA); wr('h2AAA, 'h54); wr('h5555, 'h80); unlock(); wr('h00000, 'h30); idle(2);
        spot("R6", 4, 0, 0);

        tag = "R7";
        unlock(); wr('h5555, 'hA0, 1'b1); wr('h5555, 'hA0); wr('h0AAAA, 'h99, 1'b1); idle(2);
        spot("R7", 4, 0, 0);
        wr('h0BBBB, 'h42); idle(2);
        spot("R7", 1, 'h0BBBB, 0);

        tag = "R8";
        unlock(); wr('h5555, 'h90);
        rd_addr = 0; idle(1);
        check("R8", "manufacturer code", int'(id_byte), 'hBF);
        rd_addr = 1; idle(1);
        check("R8", "device code", int'(id_byte), 'hD8);
        rd_addr = 2; idle(1);
        rd_addr = 1;
        tag = "R7";
        wr('h0000, 'hF0, 1'b1); idle(1);
        check("R7", "exit ignored under busy", int'(mode), 1);
        tag = "R9";
        unlock(); wr('h5555, 'hA0); wr('h00200, 'h12); idle(2);
        spot("R9", 1, 'h0BBBB, 1);
        tag = "R10";
        wr('h3333, 'hF0); idle(1);
        check("R10", "single-write exit", int'(mode), 0);
        check("R8", "id quiet in read", int'(id_byte), 0);

        tag = "R9";
        unlock(); wr('h5555, 'h98); idle(1);
        check("R9", "query entry", int'(mode), 2);
        unlock(); wr('h5555, 'h90); wr('h1111, 'h22); idle(1);
        check("R9", "query kept", int'(mode), 2);
        tag = "R10";
        unlock(); wr('h5555, 'hF0); idle(1);
        check("R10", "third-write exit", int'(mode), 0);

        tag = "R12";
        unlock(); wr('h5555, 'hA0);
        @(negedge clk); wr_en = 1'b1; wr_addr = 'h00321; wr_data = 'h65;
        @(negedge clk); wr_en = 1'b0;
        check("R12", "pulse high", int'(op_start), 1);
        @(negedge clk);
        check("R12", "pulse one cycle", int'(op_start), 0);
        check("R12", "data held", int'(op_data), 'h65);
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule